// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the host-facing register set of a four-channel DMA controller. A host reaches it through an 8-bit register port that has separate write and read strobes, a register select and byte-wide data. For each channel it holds a 16-bit base address, a 16-bit base count, the matching current address and current count, a mode field and a mask bit. It also holds one command register, one status register and one temporary register. All of these values are driven out in parallel to a separate transfer engine. The engine returns updated current values, terminal-count pulses, request levels and temporary data so that the host can read them back.

Each 16-bit address or count register is reached through one byte-wide port and takes two successive accesses, low byte first. A single low/high pointer flip-flop decides which byte an access reaches. This pointer is shared by every address and count port of every channel. A write to the clear-pointer port returns it to the low byte. A master clear does the same and also brings the control state back to its reset values. The count value the host programs is one less than the number of transfers, so 0x0000 means one transfer and 0xFFFF means 65536 transfers. The block stores that value unchanged and the engine interprets it.

The register select map is as follows. Offsets 2c and 2c+1 are the address port and the count port of channel c, for offsets 0 to 7. The control ports sit at offsets 8 to 15:

- 8: command on write, status on read.
- 9: mode.
- 10: single-channel mask.
- 11: mask all channels.
- 12: clear all mask bits.
- 13: clear pointer.
- 14: master clear on write, temporary register on read.
- 15: spare.

Top module: `dmaregs_top`

## Requirements
- R1: After reset, and in the cycle after any write to offset 14, all mask bits are 1 and the command, status flags, temporary register and byte pointer are 0. Master clear leaves the address, count and mode registers unchanged.
- R2: A write to offset 2c loads the byte selected by the pointer (low when 0, high when 1) into both the base address and the current address of channel c. A write to offset 2c+1 does the same for the count.
- R3: Every read or write at offsets 0 to 7 toggles the single byte pointer. The pointer is shared across all channels and across the address and count ports.
- R4: A write of any data value to offset 13 clears the byte pointer, so the next address or count access reaches the low byte.
- R5: A read at offset 2c or 2c+1 returns the pointer-selected byte of the current address or the current count of channel c. A pulse on cur_ld_i[c] replaces both current registers of channel c with cur_addr_i and cur_cnt_i and leaves the base registers unchanged.
- R6: A write to offset 10 selects the channel with data bits [1:0]. It sets that channel's mask bit when data bit 2 is 1 and clears it when data bit 2 is 0. Other mask bits keep their value.
- R7: A write to offset 11 sets all mask bits and a write to offset 12 clears all mask bits, whatever the data value.
- R8: A write to offset 9 stores data bits [7:2] as the 6-bit mode of the channel selected by data bits [1:0]. For example, 0x44 stores 0x11 and 0xC0 stores 0x30; adding 0x10 (autoinitialize) to 0x44 stores 0x15.
- R9: A write to offset 8 sets cmd_o. A read at offset 8 returns status, with bits [3:0] holding sticky terminal-count flags set by tc_i and bits [7:4] holding live req_i. The read clears the flags, but a tc_i pulse in the same cycle still sets its flag.
- R10: A tmp_ld_i pulse loads tmp_i into the temporary register, and a read at offset 14 returns that register.
- R11: rdata is 0x00 when rd_en is low, and reads of offsets 9 to 13 and 15 return 0x00. Reads at offsets 8 to 15 leave the byte pointer unchanged. When wr_en and rd_en are both high, the access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 4 | Register offset |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte (combinational) |
| base_addr_o | output | 64 | Base address per channel, channel c at [16c+15:16c] |
| base_cnt_o | output | 64 | Base count per channel |
| cur_addr_o | output | 64 | Current address per channel |
| cur_cnt_o | output | 64 | Current count per channel |
| mode_o | output | 24 | 6-bit mode per channel |
| mask_o | output | 4 | Mask bit per channel, 1 = disabled |
| cmd_o | output | 8 | Command register |
| cur_ld_i | input | 4 | Per-channel load strobe for current values |
| cur_addr_i | input | 64 | Current address from the engine |
| cur_cnt_i | input | 64 | Current count from the engine |
| tc_i | input | 4 | Terminal-count pulses |
| req_i | input | 4 | Request levels shown in status |
| tmp_ld_i | input | 1 | Temporary register load strobe |
| tmp_i | input | 8 | Temporary data from the engine |

## Verification
The byte pointer is the one hidden state bit that touches every 16-bit register. If it goes wrong, the next address or count access lands on the wrong byte: a write changes the other half of base_addr_o or base_cnt_o in the following cycle, and a read returns the other half on rdata in the same cycle. The status flags, the temporary register and the mode fields show a wrong value on the first read of offsets 8 or 14, or on mode_o one cycle after the write. The reference model therefore compares every exported register after every clock and checks every read byte. Ports are interleaved across channels, so a pointer error shows within one access.

// File: rtl/dmaregs_pkg.sv
package dmaregs_pkg;

   // Control port, as offset above the last data port
   typedef enum logic [2:0] {
      CTL_CMD     = 3'd0,   // write command / read status
      CTL_MODE    = 3'd1,
      CTL_MASK1   = 3'd2,
      CTL_MASKALL = 3'd3,
      CTL_UNMASK  = 3'd4,
      CTL_CLRPTR  = 3'd5,
      CTL_MCLR    = 3'd6,   // write master clear / read temporary
      CTL_SPARE   = 3'd7
   } ctl_op_e;

endpackage

// File: rtl/dmaregs_ptr.sv
module dmaregs_ptr (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic clr,
   output logic ptr_o
);

   logic ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr_q <= 1'b0;
      else if (clr)  ptr_q <= 1'b0;
      else if (step) ptr_q <= ~ptr_q;
   end

   assign ptr_o = ptr_q;

   // R3
   ptr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr) |=> (ptr_q != $past(ptr_q)));

   // R4
   ptr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !ptr_q);

endmodule

// File: rtl/dmaregs_chan.sv
module dmaregs_chan #(
   parameter int DATA_W = 8,
   parameter int REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_addr,
   input  logic              wr_cnt,
   input  logic              hi,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ld,
   input  logic [REG_W-1:0]  ld_addr,
   input  logic [REG_W-1:0]  ld_cnt,
   output logic [REG_W-1:0]  base_addr_o,
   output logic [REG_W-1:0]  base_cnt_o,
   output logic [REG_W-1:0]  cur_addr_o,
   output logic [REG_W-1:0]  cur_cnt_o
);

   logic [REG_W-1:0] base_a_q, base_c_q, cur_a_q, cur_c_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_a_q <= '0;
         base_c_q <= '0;
         cur_a_q  <= '0;
         cur_c_q  <= '0;
      end else begin
         if (ld) begin
            cur_a_q <= ld_addr;
            cur_c_q <= ld_cnt;
         end
         if (wr_addr) begin
            if (hi) begin
               base_a_q[REG_W-1:DATA_W] <= wdata;
               cur_a_q[REG_W-1:DATA_W]  <= wdata;
            end else begin
               base_a_q[DATA_W-1:0] <= wdata;
               cur_a_q[DATA_W-1:0]  <= wdata;
            end
         end
         if (wr_cnt) begin
            if (hi) begin
               base_c_q[REG_W-1:DATA_W] <= wdata;
               cur_c_q[REG_W-1:DATA_W]  <= wdata;
            end else begin
               base_c_q[DATA_W-1:0] <= wdata;
               cur_c_q[DATA_W-1:0]  <= wdata;
            end
         end
      end
   end

   assign base_addr_o = base_a_q;
   assign base_cnt_o  = base_c_q;
   assign cur_addr_o  = cur_a_q;
   assign cur_cnt_o   = cur_c_q;

   // R2
   lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_addr && !hi) |=> (base_a_q[DATA_W-1:0] == $past(wdata)
                            && cur_a_q[DATA_W-1:0] == $past(wdata)));

   // R5
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !wr_addr && !wr_cnt) |=> ($stable(base_a_q) && $stable(base_c_q)));

endmodule

// File: rtl/dmaregs_ctl.sv
module dmaregs_ctl
   import dmaregs_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int DATA_W   = 8,
   parameter int CH_SEL_W = 2,
   parameter int MODE_W   = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr,
   input  ctl_op_e                  op,
   input  logic [DATA_W-1:0]        wdata,
   input  logic                     status_rd,
   input  logic [NUM_CH-1:0]        tc_i,
   input  logic                     tmp_ld,
   input  logic [DATA_W-1:0]        tmp_i,
   output logic [NUM_CH-1:0]        mask_o,
   output logic [NUM_CH*MODE_W-1:0] mode_o,
   output logic [DATA_W-1:0]        cmd_o,
   output logic [NUM_CH-1:0]        tcf_o,
   output logic [DATA_W-1:0]        tmp_o
);

   logic [CH_SEL_W-1:0] sel_ch;
   logic                sel_flag;
   logic [MODE_W-1:0]   mode_fld;
   logic do_cmd, do_mode, do_mask1, do_maskall, do_unmask, do_mclr;

   assign sel_ch     = wdata[CH_SEL_W-1:0];
   assign sel_flag   = wdata[CH_SEL_W];
   assign mode_fld   = wdata[DATA_W-1:CH_SEL_W];
   assign do_cmd     = wr && (op == CTL_CMD);
   assign do_mode    = wr && (op == CTL_MODE);
   assign do_mask1   = wr && (op == CTL_MASK1);
   assign do_maskall = wr && (op == CTL_MASKALL);
   assign do_unmask  = wr && (op == CTL_UNMASK);
   assign do_mclr    = wr && (op == CTL_MCLR);

   logic [NUM_CH-1:0] mask_q, tcf_q;
   logic [DATA_W-1:0] cmd_q, tmp_q;
   logic [MODE_W-1:0] mode_q [NUM_CH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      mask_q <= '1;
      else if (do_mclr || do_maskall)  mask_q <= '1;
      else if (do_unmask)              mask_q <= '0;
      else if (do_mask1)               mask_q[sel_ch] <= sel_flag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         tcf_q <= '0;
         tmp_q <= '0;
      end else if (do_mclr) begin
         cmd_q <= '0;
         tcf_q <= '0;
         tmp_q <= '0;
      end else begin
         if (do_cmd) cmd_q <= wdata;
         tcf_q <= (status_rd ? '0 : tcf_q) | tc_i;
         if (tmp_ld) tmp_q <= tmp_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) mode_q[i] <= '0;
      end else if (do_mode) begin
         mode_q[sel_ch] <= mode_fld;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
      assign mode_o[c*MODE_W +: MODE_W] = mode_q[c];
   end

   assign mask_o = mask_q;
   assign cmd_o  = cmd_q;
   assign tcf_o  = tcf_q;
   assign tmp_o  = tmp_q;

   // R1
   mclr_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_mclr |=> ((&mask_q) && cmd_q == '0 && tcf_q == '0 && tmp_q == '0));

   // R6
   single_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_mask1 |=> $onehot0(mask_q ^ $past(mask_q)));

   // R7
   mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_maskall |=> (&mask_q));

   // R9
   tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|tc_i) && !do_mclr) |=> ((tcf_q & $past(tc_i)) == $past(tc_i)));

endmodule

// File: rtl/dmaregs_top.sv
module dmaregs_top
   import dmaregs_pkg::*;
#(
   parameter  int NUM_CH   = 4,
   parameter  int DATA_W   = 8,
   parameter  int REG_W    = 16,
   localparam int CH_SEL_W = $clog2(NUM_CH),
   localparam int MODE_W   = DATA_W - CH_SEL_W,
   localparam int SEL_W    = $clog2(2*NUM_CH + 8)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [SEL_W-1:0]         reg_sel,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata,
   output logic [NUM_CH*REG_W-1:0]  base_addr_o,
   output logic [NUM_CH*REG_W-1:0]  base_cnt_o,
   output logic [NUM_CH*REG_W-1:0]  cur_addr_o,
   output logic [NUM_CH*REG_W-1:0]  cur_cnt_o,
   output logic [NUM_CH*MODE_W-1:0] mode_o,
   output logic [NUM_CH-1:0]        mask_o,
   output logic [DATA_W-1:0]        cmd_o,
   input  logic [NUM_CH-1:0]        cur_ld_i,
   input  logic [NUM_CH*REG_W-1:0]  cur_addr_i,
   input  logic [NUM_CH*REG_W-1:0]  cur_cnt_i,
   input  logic [NUM_CH-1:0]        tc_i,
   input  logic [NUM_CH-1:0]        req_i,
   input  logic                     tmp_ld_i,
   input  logic [DATA_W-1:0]        tmp_i
);

   // elaboration-time parameter checks
   if (REG_W != 2*DATA_W) begin : g_bad_reg_w
      $error("REG_W must be twice DATA_W");
   end
   if (NUM_CH < 2 || (1 << CH_SEL_W) != NUM_CH) begin : g_bad_num_ch
      $error("NUM_CH must be a power of two, at least 2");
   end
   if (2*NUM_CH > DATA_W || CH_SEL_W >= DATA_W) begin : g_bad_data_w
      $error("DATA_W too narrow for status or channel select");
   end

   // decode
   logic                wr, rd, is_data, is_ctl, is_cnt, ptr;
   logic [SEL_W-1:0]    ctl_off;
   logic [CH_SEL_W-1:0] dch;
   ctl_op_e             op;

   assign wr      = wr_en;
   assign rd      = rd_en && !wr_en;
   assign is_data = (reg_sel < SEL_W'(2*NUM_CH));
   assign ctl_off = reg_sel - SEL_W'(2*NUM_CH);
   assign is_ctl  = !is_data && (ctl_off < SEL_W'(8));
   assign op      = ctl_op_e'(ctl_off[2:0]);
   assign dch     = reg_sel[CH_SEL_W:1];
   assign is_cnt  = reg_sel[0];

   dmaregs_ptr u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  ((wr || rd) && is_data),
      .clr   (wr && is_ctl && (op == CTL_CLRPTR || op == CTL_MCLR)),
      .ptr_o (ptr)
   );

   // channel register sets
   logic [REG_W-1:0] cur_a_w [NUM_CH];
   logic [REG_W-1:0] cur_c_w [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit = wr && is_data && (dch == CH_SEL_W'(c));

      dmaregs_chan #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr_addr     (hit && !is_cnt),
         .wr_cnt      (hit && is_cnt),
         .hi          (ptr),
         .wdata       (wdata),
         .ld          (cur_ld_i[c]),
         .ld_addr     (cur_addr_i[c*REG_W +: REG_W]),
         .ld_cnt      (cur_cnt_i[c*REG_W +: REG_W]),
         .base_addr_o (base_addr_o[c*REG_W +: REG_W]),
         .base_cnt_o  (base_cnt_o[c*REG_W +: REG_W]),
         .cur_addr_o  (cur_addr_o[c*REG_W +: REG_W]),
         .cur_cnt_o   (cur_cnt_o[c*REG_W +: REG_W])
      );

      assign cur_a_w[c] = cur_addr_o[c*REG_W +: REG_W];
      assign cur_c_w[c] = cur_cnt_o[c*REG_W +: REG_W];
   end

   // control registers
   logic [NUM_CH-1:0] tcf;
   logic [DATA_W-1:0] tmp;

   dmaregs_ctl #(
      .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_SEL_W(CH_SEL_W), .MODE_W(MODE_W)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr && is_ctl),
      .op        (op),
      .wdata     (wdata),
      .status_rd (rd && is_ctl && op == CTL_CMD),
      .tc_i      (tc_i),
      .tmp_ld    (tmp_ld_i),
      .tmp_i     (tmp_i),
      .mask_o    (mask_o),
      .mode_o    (mode_o),
      .cmd_o     (cmd_o),
      .tcf_o     (tcf),
      .tmp_o     (tmp)
   );

   // read path
   logic [REG_W-1:0] cur_sel;

   always_comb begin
      cur_sel = is_cnt ? cur_c_w[dch] : cur_a_w[dch];
      rdata   = '0;
      if (rd) begin
         if (is_data) begin
            rdata = ptr ? cur_sel[REG_W-1:DATA_W] : cur_sel[DATA_W-1:0];
         end else if (is_ctl && op == CTL_CMD) begin
            rdata = DATA_W'({req_i, tcf});
         end else if (is_ctl && op == CTL_MCLR) begin
            rdata = tmp;
         end
      end
   end

   // R11
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rdata == '0));

endmodule

// File: tb/test_dmaregs_top.sv
module test_dmaregs_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0]  reg_sel = '0;
   logic [7:0]  wdata = '0, rdata;
   logic [63:0] base_addr_o, base_cnt_o, cur_addr_o, cur_cnt_o;
   logic [23:0] mode_o;
   logic [3:0]  mask_o;
   logic [7:0]  cmd_o;
   logic [3:0]  cur_ld_i = '0, tc_i = '0, req_i = '0;
   logic [63:0] cur_addr_i = '0, cur_cnt_i = '0;
   logic        tmp_ld_i = 1'b0;
   logic [7:0]  tmp_i = '0;

   always #2 clk = ~clk;

   dmaregs_top i_dmaregs_top (.*);

   int    n_chk = 0, n_bad = 0;
   string tag = "R1";

   // behavioural reference state
   int m_ba[4], m_ca[4], m_bc[4], m_cc[4], m_mode[4];
   int m_mask = 15, m_cmd = 0, m_tcf = 0, m_tmp = 0, m_ptr = 0;

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int put_byte(int v, int hi, int d);
      if (hi != 0) return (v & 'hFF) | ((d & 'hFF) << 8);
      return (v & 'hFF00) | (d & 'hFF);
   endfunction

   function automatic int model_read(int sel);
      int v;
      if (sel < 8) begin
         v = (sel % 2 == 0) ? m_ca[sel/2] : m_cc[sel/2];
         return (m_ptr != 0) ? ((v >> 8) & 'hFF) : (v & 'hFF);
      end
      if (sel == 8)  return ((int'(req_i) << 4) | m_tcf) & 'hFF;
      if (sel == 14) return m_tmp;
      return 0;
   endfunction

   task automatic model_update(bit w, bit r, int sel, int d);
      bit mclr = w && sel == 14;
      for (int c = 0; c < 4; c++)
         if (cur_ld_i[c]) begin
            m_ca[c] = int'(cur_addr_i[c*16 +: 16]);
            m_cc[c] = int'(cur_cnt_i[c*16 +: 16]);
         end
      if (w) begin
         if (sel < 8) begin
            if (sel % 2 == 0) begin
               m_ba[sel/2] = put_byte(m_ba[sel/2], m_ptr, d);
               m_ca[sel/2] = put_byte(m_ca[sel/2], m_ptr, d);
            end else begin
               m_bc[sel/2] = put_byte(m_bc[sel/2], m_ptr, d);
               m_cc[sel/2] = put_byte(m_cc[sel/2], m_ptr, d);
            end
            m_ptr ^= 1;
         end else begin
            case (sel)
               8:  m_cmd = d;
               9:  m_mode[d & 3] = (d >> 2) & 63;
               10: if ((d & 4) != 0) m_mask |= (1 << (d & 3));
                   else m_mask &= ~(1 << (d & 3)) & 15;
               11: m_mask = 15;
               12: m_mask = 0;
               13: m_ptr = 0;
               14: begin m_mask = 15; m_cmd = 0; m_tcf = 0; m_tmp = 0; m_ptr = 0; end
               default: ;
            endcase
         end
      end else if (r) begin
         if (sel < 8) m_ptr ^= 1;
         else if (sel == 8) m_tcf = 0;
      end
      if (!mclr) begin
         m_tcf |= int'(tc_i);
         if (tmp_ld_i) m_tmp = int'(tmp_i);
      end
   endtask

   task automatic compare_all();
      for (int c = 0; c < 4; c++) begin
         chk(base_addr_o[c*16 +: 16], 64'(m_ba[c]), $sformatf("base_addr ch%0d", c));
         chk(base_cnt_o[c*16 +: 16],  64'(m_bc[c]), $sformatf("base_cnt ch%0d", c));
         chk(cur_addr_o[c*16 +: 16],  64'(m_ca[c]), $sformatf("cur_addr ch%0d", c));
         chk(cur_cnt_o[c*16 +: 16],   64'(m_cc[c]), $sformatf("cur_cnt ch%0d", c));
         chk(mode_o[c*6 +: 6],        64'(m_mode[c]), $sformatf("mode ch%0d", c));
      end
      chk(mask_o, 64'(m_mask), "mask");
      chk(cmd_o,  64'(m_cmd),  "cmd");
   endtask

   // one clock: drive after negedge, check read, model at posedge, compare at next negedge
   task automatic step(bit w, bit r, int sel, int d);
      wr_en = w; rd_en = r; reg_sel = 4'(sel); wdata = 8'(d);
      #1;
      if (r) chk(rdata, 64'(model_read(sel)), $sformatf("rdata sel%0d", sel));
      else   chk(rdata, 64'h0, "idle rdata R11");
      @(posedge clk);
      model_update(w, r, sel, d);
      @(negedge clk);
      wr_en = 0; rd_en = 0; cur_ld_i = '0; tc_i = '0; tmp_ld_i = 0;
      compare_all();
   endtask

   task automatic wr(int sel, int d); step(1, 0, sel, d); endtask
   task automatic rd(int sel);        step(0, 1, sel, 0); endtask
   task automatic idle();             step(0, 0, 0, 0);   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int c = 0; c < 4; c++) begin
         m_ba[c] = 0; m_ca[c] = 0; m_bc[c] = 0; m_cc[c] = 0; m_mode[c] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      tag = "R1"; compare_all(); rd(8); rd(14); rd(0);
      wr(13, 0);

      // R2 full loads on every channel
      tag = "R2";
      for (int c = 0; c < 4; c++) begin
         wr(2*c, 'h10 + c); wr(2*c, 'hA0 + c);
         wr(2*c+1, 'h3C - c); wr(2*c+1, 'h05 + c);
      end
      wr(7, 'hFF); wr(7, 'hFF);

      // R3 pointer shared across ports and channels, toggled by reads
      tag = "R3";
      wr(0, 'h11); wr(1, 'h22); rd(2); rd(3); wr(5, 'h77); rd(5); rd(5);

      // R4 clear pointer with arbitrary data
      tag = "R4";
      wr(13, 'hA5); wr(4, 'h99); wr(13, 'h00); wr(4, 'h98); rd(4); rd(4);

      // R5 readback and engine loads
      tag = "R5";
      wr(13, 0);
      cur_ld_i = 4'b0100; cur_addr_i[32 +: 16] = 16'hBEEF; cur_cnt_i[32 +: 16] = 16'h0123;
      idle();
      for (int s = 0; s < 8; s++) begin rd(s); rd(s); end

      // R6 single mask
      tag = "R6";
      wr(12, 0); wr(10, 'h06); wr(10, 'h04); wr(10, 'hF9); wr(10, 'h02); wr(10, 'h03);
      wr(10, 'h07);

      // R7 mask all / clear all
      tag = "R7";
      wr(11, 'h00); wr(12, 'hFF); wr(11, 'h5A); wr(12, 'h00);

      // R8 modes
      tag = "R8";
      wr(9, 'h44); wr(9, 'h49); wr(9, 'hC2); wr(9, 'h57); wr(9, 'h48);

      // R9 command and status
      tag = "R9";
      wr(8, 'h3C); req_i = 4'b1010; tc_i = 4'b0101; idle();
      rd(8); rd(8);
      tc_i = 4'b0010; rd(8); rd(8); wr(8, 'hC3);

      // R10 temporary register
      tag = "R10";
      tmp_ld_i = 1; tmp_i = 'h5A; idle(); rd(14); rd(14);

      // R11 write-only ports read zero and do not move the pointer
      tag = "R11";
      wr(13, 0); rd(9); rd(10); rd(11); rd(12); rd(13); rd(15); rd(0);
      rd(8); rd(14); rd(1);
      wr_en = 1; rd_en = 1; reg_sel = 4'd2; wdata = 8'h66;
      @(posedge clk); model_update(1, 0, 2, 'h66);
      @(negedge clk); wr_en = 0; rd_en = 0; compare_all();

      // R1 master clear
      tag = "R1";
      tc_i = 4'b1111; idle(); wr(11, 0); wr(8, 'h81);
      wr(0, 'h12); wr(14, 'h77); rd(8); rd(14); rd(0); rd(0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule